// File: doc/BRIEF.md
# Constellation Eye-Pattern Deserializer

This block turns the diagnostic serial stream that a modem uses to report received constellation points into two parallel coordinate bytes for a pair of digital-to-analog converters. The stream arrives on three wires: a bit clock, a data line, and a framing strobe. Every frame carries two 11-bit words, X first and then Y. Each word is sent most significant bit first, and only its upper 8 bits carry information.

The three wires are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and rising edges are found in the system clock domain. The system clock must therefore be several times faster than the bit clock. In the intended setting the bit clock runs at 336 kHz. A 22-bit shift register collects the bits. A rising edge of the strobe loads both coordinates into the output registers and raises a one-cycle update pulse. If the strobe arrives before a full frame has been collected, the outputs are left alone and a sticky error flag is set.

Top module: `eye_deser`

## Requirements
- R1: While rst_n is low at a clock edge, x_o and y_o go to 0, and upd_o and frm_err_o go to 0.
- R2: Data is taken only on rising edges of ser_clk_i, most significant bit first. x_o takes the upper 8 bits of the first 11-bit word of the frame.
- R3: y_o takes the upper 8 bits of the second 11-bit word, which is the word received last before the strobe.
- R4: The lowest 3 bits of each word have no effect on x_o or y_o.
- R5: Bits that arrive without a following strobe rising edge leave x_o and y_o unchanged.
- R6: Each accepted load raises upd_o for exactly one system cycle, in the same cycle that the new x_o and y_o first appear.
- R7: A strobe rising edge that comes after fewer than 22 bits since the previous strobe (or since reset) sets frm_err_o. It leaves x_o and y_o unchanged and raises no upd_o pulse.
- R8: Once frm_err_o is set, it stays high until reset.
- R9: If more than 22 bits arrive between strobes, the last 22 bits before the strobe form the frame.
- R10: An input change that is first sampled at system edge k is acted on at edge k+2, and the result is visible on the outputs after that edge.
- R11: Changes of ser_dat_i while ser_clk_i is high, or with no rising edge of ser_clk_i, do not enter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, taken on bit-clock rising edge |
| ser_sync_i | input | 1 | Frame load strobe, rising edge active |
| x_o | output | SIG_W (8) | X coordinate byte |
| y_o | output | SIG_W (8) | Y coordinate byte |
| upd_o | output | 1 | One-cycle pulse on each accepted load |
| frm_err_o | output | 1 | Sticky short-frame flag |

## Verification
The properties assume that every high and low phase of the bit clock and the strobe lasts at least two system cycles. Under that assumption, two strobe rising edges can never be seen in consecutive cycles, so an update pulse can never be followed directly by another one. The stimulus holds every bit-clock phase and every strobe phase for three system cycles. It changes the three serial inputs only on falling edges of the system clock, and it keeps them all low while reset is applied. The bench's reference model treats the inputs as zero before reset for the same reason.

// File: rtl/eye_deser_pkg.sv
// Shared constants for the eye-pattern deserializer.
// Assumes the three serial lanes are packed as {clk, dat, sync}.
package eye_deser_pkg;
    localparam int EYE_WORD_W      = 11;
    localparam int EYE_SIG_W       = 8;
    localparam int EYE_SYNC_STAGES = 2;
    localparam int LANE_SYNC       = 0;
    localparam int LANE_DAT        = 1;
    localparam int LANE_CLK        = 2;
    localparam int LANES           = 3;
endpackage

// File: rtl/eye_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit lanes.
// Assumes every lane is a level that is slow compared with clk.
module eye_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw asynchronous lanes
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            // Later stages let any metastable value settle
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eye_edge.sv
// Rising-edge detector for synchronised lanes.
// Assumes the inputs are already in the clk domain.
module eye_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Keep the previous level of each lane
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rise_o[b] = lvl_i[b] & ~prev_q[b];
    end
endmodule

// File: rtl/eye_frame_sr.sv
// Frame shift register with a saturating bit counter.
// The oldest bit sits at the top of the register. The field outputs show the
// register before any shift that happens in the same cycle.
module eye_frame_sr #(
    parameter int WORD_W = 11,
    parameter int SIG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic             restart_i,
    output logic             full_o,
    output logic [SIG_W-1:0] x_field_o,
    output logic [SIG_W-1:0] y_field_o
);
    localparam int FRAME_W = 2 * WORD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;

    // Shift in a new bit on each serial clock rise, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
    end

    // Count bits since the last strobe, saturating at one frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart_i)
            cnt_q <= shift_i ? CNT_W'(1) : '0;
        else if (shift_i && cnt_q != CNT_FULL)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign full_o    = (cnt_q == CNT_FULL);
    assign x_field_o = sr_q[FRAME_W-1 -: SIG_W];
    assign y_field_o = sr_q[WORD_W-1 -: SIG_W];
endmodule

// File: rtl/eye_deser.sv
// Top of the eye-pattern deserializer. It synchronises the serial lanes,
// collects a two-word frame and loads both coordinates on the strobe rising
// edge. Assumes every serial phase lasts at least STAGES system cycles.
module eye_deser
    import eye_deser_pkg::*;
#(
    parameter int WORD_W      = EYE_WORD_W,
    parameter int SIG_W       = EYE_SIG_W,
    parameter int SYNC_STAGES = EYE_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_sync_i,
    output logic [SIG_W-1:0] x_o,
    output logic [SIG_W-1:0] y_o,
    output logic             upd_o,
    output logic             frm_err_o
);
    logic [LANES-1:0] raw_lanes;
    logic [LANES-1:0] syn_lanes;
    logic [LANES-1:0] rise_lanes;
    logic             frame_full;
    logic [SIG_W-1:0] x_field;
    logic [SIG_W-1:0] y_field;
    logic             load_ok;
    logic             load_short;

    assign raw_lanes[LANE_CLK]  = ser_clk_i;
    assign raw_lanes[LANE_DAT]  = ser_dat_i;
    assign raw_lanes[LANE_SYNC] = ser_sync_i;

    eye_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lanes),
        .q_o   (syn_lanes)
    );

    eye_edge #(.W(LANES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (syn_lanes),
        .rise_o (rise_lanes)
    );

    eye_frame_sr #(.WORD_W(WORD_W), .SIG_W(SIG_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (rise_lanes[LANE_CLK]),
        .bit_i     (syn_lanes[LANE_DAT]),
        .restart_i (rise_lanes[LANE_SYNC]),
        .full_o    (frame_full),
        .x_field_o (x_field),
        .y_field_o (y_field)
    );

    assign load_ok    = rise_lanes[LANE_SYNC] &  frame_full;
    assign load_short = rise_lanes[LANE_SYNC] & ~frame_full;

    // Load the coordinates on a full-frame strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
        end else if (load_ok) begin
            x_o <= x_field;
            y_o <= y_field;
        end
    end

    // Pulse the update strobe together with the new coordinates
    always_ff @(posedge clk) begin
        if (!rst_n) upd_o <= 1'b0;
        else        upd_o <= load_ok;
    end

    // Latch a short-frame error until reset
    always_ff @(posedge clk) begin
        if (!rst_n)          frm_err_o <= 1'b0;
        else if (load_short) frm_err_o <= 1'b1;
    end
endmodule

// File: rtl/eye_deser_chk.sv
// Checker for eye_deser, attached with bind. Observes the ports only.
module eye_deser_chk #(
    parameter int SIG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SIG_W-1:0] x_o,
    input logic [SIG_W-1:0] y_o,
    input logic             upd_o,
    input logic             frm_err_o
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (x_o == '0 && y_o == '0 && !upd_o && !frm_err_o));

    // R5
    hold_coord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> ($stable(x_o) && $stable(y_o)));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R7
    err_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_err_o) |-> !upd_o);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |=> frm_err_o);
endmodule

bind eye_deser eye_deser_chk #(.SIG_W(SIG_W)) u_eye_deser_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_o       (x_o),
    .y_o       (y_o),
    .upd_o     (upd_o),
    .frm_err_o (frm_err_o)
);

// File: tb/test_eye_deser.sv
// Bench for eye_deser: a behavioural per-cycle model plus directed checks.
module test_eye_deser;
    localparam int WORD = 11;
    localparam int SIG  = 8;
    localparam int FR   = 2 * WORD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_sync = 1'b0;
    logic [SIG-1:0] x_o;
    logic [SIG-1:0] y_o;
    logic upd_o;
    logic frm_err_o;

    int vectors = 0;
    int fails = 0;
    int pulses = 0;
    int cycles = 0;

    eye_deser i_eye_deser (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .ser_sync_i(ser_sync), .x_o(x_o), .y_o(y_o), .upd_o(upd_o),
        .frm_err_o(frm_err_o)
    );

    always #10 clk = ~clk;

    // Reference model state
    logic [2:0] hist[$];
    bit bits[$];
    int nbits;
    int ex, ey;
    bit eupd, eerr;

    always @(posedge clk) begin
        logic [2:0] cur, prv;
        if (!rst_n) begin
            hist = '{3'b000, 3'b000, 3'b000};
            bits = {};
            nbits = 0; ex = 0; ey = 0; eupd = 0; eerr = 0;
        end else begin
            cur = hist[1];
            prv = hist[0];
            eupd = 0;
            if (cur[0] && !prv[0]) begin
                if (nbits >= FR) begin
                    ex = 0; ey = 0;
                    for (int i = 0; i < SIG; i++) begin
                        ex = (ex << 1) | int'(bits[i]);
                        ey = (ey << 1) | int'(bits[WORD + i]);
                    end
                    eupd = 1;
                end else begin
                    eerr = 1;
                end
                nbits = 0;
            end
            if (cur[2] && !prv[2]) begin
                bits.push_back(cur[1]);
                if (bits.size() > FR) void'(bits.pop_front());
                nbits++;
            end
            hist.push_back({ser_clk, ser_dat, ser_sync});
            void'(hist.pop_front());
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_o) pulses++;
            chk(x_o == ex[SIG-1:0], "R10 cycle x_o (R2)", x_o, ex);
            chk(y_o == ey[SIG-1:0], "R10 cycle y_o (R3)", y_o, ey);
            chk(upd_o == eupd, "R10 cycle upd_o (R6)", upd_o, eupd);
            chk(frm_err_o == eerr, "R10 cycle frm_err_o (R7)", frm_err_o, eerr);
        end
    end

    task automatic send_bit(input bit b, input bit glitch);
        @(negedge clk); ser_dat = b; ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        @(negedge clk);
        if (glitch) ser_dat = ~b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(input logic [SIG-1:0] sig, input logic [2:0] low, input bit glitch);
        logic [WORD-1:0] w;
        w = {sig, low};
        for (int i = WORD - 1; i >= 0; i--) send_bit(w[i], glitch);
    endtask

    task automatic strobe();
        @(negedge clk); ser_sync = 1'b1;
        repeat (3) @(negedge clk);
        ser_sync = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input logic [SIG-1:0] x, input logic [2:0] lx,
                         input logic [SIG-1:0] y, input logic [2:0] ly, input bit glitch);
        send_word(x, lx, glitch);
        send_word(y, ly, glitch);
        strobe();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; ser_clk = 0; ser_dat = 0; ser_sync = 0;
        repeat (4) @(negedge clk);
        chk(x_o == 0 && y_o == 0, "R1 coords in reset", {x_o, y_o}, 0);
        chk(!upd_o && !frm_err_o, "R1 flags in reset", {upd_o, frm_err_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        int p0;
        do_reset();
        repeat (3) @(negedge clk);

        // R2 R3: basic frame
        p0 = pulses;
        frame(8'hA5, 3'b011, 8'h3C, 3'b101, 0);
        chk(x_o == 8'hA5, "R2 x from first word", x_o, 8'hA5);
        chk(y_o == 8'h3C, "R3 y from second word", y_o, 8'h3C);
        chk(pulses - p0 == 1, "R6 one pulse per load", pulses - p0, 1);

        frame(8'h5A, 3'b000, 8'hC3, 3'b111, 0);
        chk(x_o == 8'h5A && y_o == 8'hC3, "R2 second frame", {x_o, y_o}, 16'h5AC3);

        // R4: only the low bits differ
        p0 = pulses;
        frame(8'h5A, 3'b111, 8'hC3, 3'b000, 0);
        chk(x_o == 8'h5A && y_o == 8'hC3, "R4 low bits ignored", {x_o, y_o}, 16'h5AC3);
        chk(pulses - p0 == 1, "R6 pulse on equal values", pulses - p0, 1);

        // R11: data flips while the bit clock is high
        frame(8'h81, 3'b010, 8'h7E, 3'b100, 1);
        chk(x_o == 8'h81 && y_o == 8'h7E, "R11 data after rise ignored", {x_o, y_o}, 16'h817E);

        // R9: three leading extra bits
        send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
        frame(8'h0F, 3'b001, 8'hF0, 3'b110, 0);
        chk(x_o == 8'h0F && y_o == 8'hF0, "R9 last 22 bits used", {x_o, y_o}, 16'h0FF0);

        // R5: a full frame with no strobe
        send_word(8'h33, 3'b000, 0);
        send_word(8'h44, 3'b000, 0);
        repeat (8) @(negedge clk);
        chk(x_o == 8'h0F && y_o == 8'hF0, "R5 no strobe no change", {x_o, y_o}, 16'h0FF0);
        strobe();
        chk(x_o == 8'h33 && y_o == 8'h44, "R5 strobe then loads", {x_o, y_o}, 16'h3344);

        // R7: short frame
        p0 = pulses;
        for (int i = 0; i < 10; i++) send_bit(i[0], 0);
        strobe();
        chk(frm_err_o == 1'b1, "R7 short frame flagged", frm_err_o, 1);
        chk(x_o == 8'h33 && y_o == 8'h44, "R7 coords kept", {x_o, y_o}, 16'h3344);
        chk(pulses - p0 == 0, "R7 no pulse", pulses - p0, 0);

        // R8: a good frame afterwards keeps the flag
        frame(8'hE7, 3'b101, 8'h18, 3'b010, 0);
        chk(x_o == 8'hE7 && y_o == 8'h18, "R8 later frame loads", {x_o, y_o}, 16'hE718);
        chk(frm_err_o == 1'b1, "R8 flag sticky", frm_err_o, 1);

        // R1: reset clears everything
        do_reset();
        repeat (3) @(negedge clk);
        chk(frm_err_o == 1'b0, "R1 flag cleared after reset", frm_err_o, 0);

        finish_run();
    end
endmodule